// File: doc/BRIEF.md
# Hardware Start/Stop Trigger Selector

This block decides which external events start and halt a pulse generator core. It watches one external trigger pin and a bank of comparator outputs. All of them are treated as asynchronous digital levels. Each one passes through a two-flop synchroniser, and its rising and falling edges are found by comparing the synchronised value with the value one clock earlier.

A 2-bit start code and a 3-bit stop code pick the edges that count. Two enable bits gate the pin's rising edge and its falling edge. The block delivers registered, single-clock start and stop pulses to the generator core. One stop code accepts an edge on any of comparator channels 1, 2 and 3. When a start and a stop fall in the same clock, only the stop is issued.

The block keeps no run state. Every qualifying start edge yields a start pulse, whether or not the core is already counting. This lets a hardware start retrigger the core at any time.

Top module: `trig_edge_select`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, start_pulse and stop_pulse are both 0.
- R2: Start code 00 makes a rising edge of pin_in a start event, but only while pin_rise_en is 1. With pin_rise_en at 0, pin_in never causes a start.
- R3: Start code 01 makes a rising edge of comparator channel 0 a start event. Code 10 does the same for its falling edge, and code 11 for either edge.
- R4: Stop code 000 makes a falling edge of pin_in a stop event, but only while pin_fall_en is 1. With pin_fall_en at 0, pin_in never causes a stop.
- R5: Stop codes 001, 010 and 011 make, in turn, the rising edge, the falling edge, or either edge of comparator channel 1 a stop event.
- R6: Stop code 100 makes a rising edge on any of comparator channels 1, 2 or 3 a stop event. Code 101 does the same for a falling edge on any of those channels.
- R7: Stop codes 110 and 111 select no source, so stop_pulse stays 0.
- R8: If a start event and a stop event are detected in the same clock, stop_pulse is 1 and start_pulse is 0.
- R9: An input change captured at rising clock edge k gives its pulse in the cycle that follows edge k+2, and the pulse lasts exactly one clock. A held level gives no further pulses.
- R10: Every start event gives a start pulse, including start events that follow earlier start pulses with no stop in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External trigger pin, asynchronous |
| cmp_in | input | N_CMP | Comparator outputs, asynchronous; bit k is channel k |
| start_sel | input | 2 | Start source code |
| stop_sel | input | 3 | Stop source code |
| pin_rise_en | input | 1 | Enables the pin's rising edge as a start |
| pin_fall_en | input | 1 | Enables the pin's falling edge as a stop |
| start_pulse | output | 1 | One-clock start request to the generator core |
| stop_pulse | output | 1 | One-clock stop request to the generator core |

## Verification
A start and a stop can land in the same clock. The bench forces this on purpose. It toggles comparator channel 0 and channel 1 (or a channel of the 1–3 group) in the same drive cycle, with start code 01 and a stop code that watches the other channel. The pin is also used with code 00/000 and both enables set. The bench computes the expected result from its own three-cycle input history. The expected result is stop_pulse high and start_pulse low, and any other outcome counts as a miscompare. Random stimulus also produces many unplanned collisions, and these are judged by the same rule.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        SRC_PIN_RISE = 2'b00,
        SRC_C0_RISE  = 2'b01,
        SRC_C0_FALL  = 2'b10,
        SRC_C0_BOTH  = 2'b11
    } start_code_e;

    typedef enum logic [2:0] {
        STP_PIN_FALL = 3'b000,
        STP_C1_RISE  = 3'b001,
        STP_C1_FALL  = 3'b010,
        STP_C1_BOTH  = 3'b011,
        STP_GRP_RISE = 3'b100,
        STP_GRP_FALL = 3'b101,
        STP_RSV_A    = 3'b110,
        STP_RSV_B    = 3'b111
    } stop_code_e;

    typedef struct packed {
        logic start;
        logic stop;
    } trig_pulse_t;

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[LAST] & ~st_q.prev;
    assign fall_o = ~st_q.chain[LAST] & st_q.prev;

    // R9: an edge flag cannot persist, since the next cycle sees a settled level
    a_r9_rise_not_sustained: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o[0] && (st_q.chain[LAST][0] == st_q.chain[LAST-1][0])) |=> !rise_o[0]);

endmodule

// File: rtl/trig_src_decode.sv
module trig_src_decode
    import trig_pkg::*;
#(
    parameter int W      = 5,
    parameter int IDX_P  = 0,
    parameter int IDX_S  = 1,
    parameter int IDX_T  = 2,
    parameter int GRP_LO = 2,
    parameter int GRP_HI = 4
) (
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] fall_i,
    input  logic [1:0]   start_sel,
    input  logic [2:0]   stop_sel,
    input  logic         pin_rise_en,
    input  logic         pin_fall_en,
    output trig_pulse_t  raw_o
);

    logic grp_rise, grp_fall;

    assign grp_rise = |rise_i[GRP_HI:GRP_LO];
    assign grp_fall = |fall_i[GRP_HI:GRP_LO];

    always_comb begin
        raw_o = '0;
        case (start_code_e'(start_sel))
            SRC_PIN_RISE: raw_o.start = rise_i[IDX_P] & pin_rise_en;
            SRC_C0_RISE:  raw_o.start = rise_i[IDX_S];
            SRC_C0_FALL:  raw_o.start = fall_i[IDX_S];
            SRC_C0_BOTH:  raw_o.start = rise_i[IDX_S] | fall_i[IDX_S];
            default:      raw_o.start = 1'b0;
        endcase
        case (stop_code_e'(stop_sel))
            STP_PIN_FALL: raw_o.stop = fall_i[IDX_P] & pin_fall_en;
            STP_C1_RISE:  raw_o.stop = rise_i[IDX_T];
            STP_C1_FALL:  raw_o.stop = fall_i[IDX_T];
            STP_C1_BOTH:  raw_o.stop = rise_i[IDX_T] | fall_i[IDX_T];
            STP_GRP_RISE: raw_o.stop = grp_rise;
            STP_GRP_FALL: raw_o.stop = grp_fall;
            default:      raw_o.stop = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_edge_select.sv
module trig_edge_select
    import trig_pkg::*;
#(
    parameter int N_CMP       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [N_CMP-1:0] cmp_in,
    input  logic [1:0]       start_sel,
    input  logic [2:0]       stop_sel,
    input  logic             pin_rise_en,
    input  logic             pin_fall_en,
    output logic             start_pulse,
    output logic             stop_pulse
);

    localparam int W      = N_CMP + 1;
    localparam int IDX_P  = 0;
    localparam int IDX_S  = 1;
    localparam int IDX_T  = IDX_S + 1;
    localparam int GRP_LO = IDX_T;
    localparam int GRP_HI = IDX_S + 3;

    logic [W-1:0] rise, fall;
    trig_pulse_t  raw;
    trig_pulse_t  out_d, out_q;

    trig_sync_edge #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cmp_in, pin_in}),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    trig_src_decode #(
        .W(W), .IDX_P(IDX_P), .IDX_S(IDX_S), .IDX_T(IDX_T),
        .GRP_LO(GRP_LO), .GRP_HI(GRP_HI)
    ) u_dec (
        .rise_i      (rise),
        .fall_i      (fall),
        .start_sel   (start_sel),
        .stop_sel    (stop_sel),
        .pin_rise_en (pin_rise_en),
        .pin_fall_en (pin_fall_en),
        .raw_o       (raw)
    );

    always_comb begin
        out_d       = '0;
        out_d.stop  = raw.stop;
        out_d.start = raw.start & ~raw.stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign start_pulse = out_q.start;
    assign stop_pulse  = out_q.stop;

    a_r8_stop_beats_start: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !start_pulse);

    a_r7_reserved_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_sel[2:1] == 2'b11) |=> !stop_pulse);

    a_r2_pin_rise_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (start_sel == 2'b00 && !pin_rise_en) |=> !start_pulse);

    a_r4_pin_fall_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_sel == 3'b000 && !pin_fall_en) |=> !stop_pulse);

    a_r6_group_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_sel == 3'b100 && !(|rise[GRP_HI:GRP_LO])) |=> !stop_pulse);

endmodule

// File: tb/trig_edge_select_test.sv
`timescale 1ns/1ps
module trig_edge_select_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic [3:0] cmp_in = '0;
    logic [1:0] start_sel = '0;
    logic [2:0] stop_sel = '0;
    logic       pin_rise_en = 1'b0;
    logic       pin_fall_en = 1'b0;
    logic       start_pulse, stop_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // history of driven inputs: index k = value driven k drive cycles ago
    logic [4:0] hin [1:4];
    logic [1:0] h_ss;
    logic [2:0] h_ps;
    logic       h_re, h_fe;

    always #2 clk = ~clk;

    trig_edge_select uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmp_in(cmp_in),
        .start_sel(start_sel), .stop_sel(stop_sel),
        .pin_rise_en(pin_rise_en), .pin_fall_en(pin_fall_en),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse)
    );

    function automatic logic f_start(logic [4:0] r, logic [4:0] f, logic [1:0] ss, logic re);
        case (ss)
            2'b00:   return r[0] & re;
            2'b01:   return r[1];
            2'b10:   return f[1];
            default: return r[1] | f[1];
        endcase
    endfunction

    function automatic logic f_stop(logic [4:0] r, logic [4:0] f, logic [2:0] ps, logic fe);
        case (ps)
            3'b000:  return f[0] & fe;
            3'b001:  return r[2];
            3'b010:  return f[2];
            3'b011:  return r[2] | f[2];
            3'b100:  return |r[4:2];
            3'b101:  return |f[4:2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic string f_tag(logic [1:0] ss, logic [2:0] ps, logic sr, logic pr);
        if (sr && pr)              return "R8";
        if (ps[2:1] == 2'b11)      return "R7";
        if (ps[2])                 return "R6";
        if (ps == 3'b000)          return (ss == 2'b00) ? "R2/R4" : "R4";
        if (ss == 2'b00)           return "R2/R5";
        return "R3/R5/R9/R10";
    endfunction

    // check outputs at this negedge, then drive the next vector
    task automatic step(input logic p, input logic [3:0] c, input logic [1:0] ss,
                        input logic [2:0] ps, input logic re, input logic fe);
        logic [4:0] r, f;
        logic sr, pr, exp_s, exp_p;
        @(negedge clk);
        r  = hin[3] & ~hin[4];
        f  = ~hin[3] & hin[4];
        sr = f_start(r, f, h_ss, h_re);
        pr = f_stop(r, f, h_ps, h_fe);
        exp_p = pr;
        exp_s = sr & ~pr;
        n_vec++;
        if (start_pulse !== exp_s || stop_pulse !== exp_p) begin
            n_bad++;
            $display("FAIL %s start=%b exp %b stop=%b exp %b",
                     f_tag(h_ss, h_ps, sr, pr), start_pulse, exp_s, stop_pulse, exp_p);
        end
        pin_in = p; cmp_in = c; start_sel = ss; stop_sel = ps;
        pin_rise_en = re; pin_fall_en = fe;
        hin[4] = hin[3]; hin[3] = hin[2]; hin[2] = hin[1]; hin[1] = {c, p};
        h_ss = ss; h_ps = ps; h_re = re; h_fe = fe;
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++)
            step(pin_in, cmp_in, start_sel, stop_sel, pin_rise_en, pin_fall_en);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] c;
        logic p;
        void'($urandom(32'h5EED_1234));
        for (int k = 1; k <= 4; k++) hin[k] = '0;
        h_ss = '0; h_ps = '0; h_re = 0; h_fe = 0;
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        n_vec++;
        if (start_pulse !== 1'b0 || stop_pulse !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 start=%b stop=%b exp 0 0", start_pulse, stop_pulse);
        end
        rst_n = 1'b1;
        hold(3);

        // R2: pin rise with enable off, then on
        step(1, 4'h0, 2'b00, 3'b110, 0, 0); hold(4);
        step(0, 4'h0, 2'b00, 3'b110, 1, 0); hold(4);
        step(1, 4'h0, 2'b00, 3'b110, 1, 0); hold(5);
        // R4: pin fall with enable off, then on
        step(0, 4'h0, 2'b00, 3'b000, 1, 0); hold(4);
        step(1, 4'h0, 2'b00, 3'b000, 0, 1); hold(4);
        step(0, 4'h0, 2'b00, 3'b000, 0, 1); hold(5);
        // R3 / R9 / R10: channel 0 edges, repeated starts without stop
        for (int m = 1; m <= 3; m++) begin
            step(0, 4'h0, m[1:0], 3'b111, 0, 0); hold(3);
            step(0, 4'h1, m[1:0], 3'b111, 0, 0); hold(3);
            step(0, 4'h0, m[1:0], 3'b111, 0, 0); hold(3);
            step(0, 4'h1, m[1:0], 3'b111, 0, 0);
            step(0, 4'h0, m[1:0], 3'b111, 0, 0); hold(4);
        end
        // R5: channel 1 stop codes
        for (int m = 1; m <= 3; m++) begin
            step(0, 4'h2, 2'b01, m[2:0], 0, 0); hold(3);
            step(0, 4'h0, 2'b01, m[2:0], 0, 0); hold(4);
        end
        // R6: group OR on channel 3 and channel 2
        step(0, 4'h8, 2'b01, 3'b100, 0, 0); hold(3);
        step(0, 4'h0, 2'b01, 3'b101, 0, 0); hold(3);
        step(0, 4'h4, 2'b01, 3'b101, 0, 0); hold(3);
        step(0, 4'h0, 2'b01, 3'b101, 0, 0); hold(4);
        // R7: reserved stop codes see channel 1 edges and ignore them
        step(0, 4'hE, 2'b01, 3'b110, 0, 0); hold(3);
        step(0, 4'h0, 2'b01, 3'b111, 0, 0); hold(4);
        // R8: simultaneous start (ch0 rise) and stop (ch1 rise)
        step(0, 4'h3, 2'b01, 3'b001, 0, 0); hold(4);
        step(0, 4'h0, 2'b11, 3'b101, 0, 0); hold(4);
        // R8: pin-only collision is impossible; ch0 rise vs ch3 rise under group stop
        step(0, 4'h9, 2'b01, 3'b100, 0, 0); hold(4);
        step(0, 4'h0, 2'b01, 3'b100, 0, 0); hold(4);

        // constrained random: sparse toggles, occasional config change
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] ss;
            logic [2:0] ps;
            logic re, fe;
            ss = start_sel; ps = stop_sel; re = pin_rise_en; fe = pin_fall_en;
            if ($urandom_range(0, 15) == 0) begin
                ss = 2'($urandom_range(0, 3));
                ps = 3'($urandom_range(0, 7));
                re = 1'($urandom_range(0, 1));
                fe = 1'($urandom_range(0, 1));
            end
            p = pin_in;
            c = cmp_in;
            if ($urandom_range(0, 3) == 0) p = ~p;
            for (int b = 0; b < 4; b++)
                if ($urandom_range(0, 4) == 0) c[b] = ~c[b];
            step(p, c, ss, ps, re, fe);
        end
        hold(5);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule